// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Unit

This block watches the processor's instruction fetch address and raises a one-cycle breakpoint event toward the halt logic when a fetch hits a programmed address. It has up to four comparators. Each one holds a word address and a two-bit match selector, so one comparator can cover the lower halfword, the upper halfword or both halfwords of a single 32-bit word.

A debugger programs the unit through a small 32-bit register bus. A control word at offset 0x00 holds the unit-wide enable and reports how many comparators the unit has. Writes to the control word take effect only when a key bit is written as 1 in the same write. The comparator words follow at offset 0x08 and upward, one word each. The comparator count is a build parameter from 0 to 4. Slots for comparators that are not built read as zero and ignore writes.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, the unit enable and every comparator word read as 0, the event output is 0, and the control word reads only the comparator count in bits 7:4.
- R2: The control word at byte offset 0x00 has the unit enable in bit 0 and the read-only comparator count in bits 7:4. Bit 1 and all other bits read 0, and a write cannot change the count field.
- R3: A write to the control word changes nothing unless bit 1 of the write data is 1.
- R4: Comparator k lives at byte offset 0x08 + 4*k. It holds the word address in bits 28:2, the match selector in bits 31:30 and its enable in bit 0. Bits 29 and 1 read 0. Any other offset reads 0.
- R5: Fetch-address bit 1 chooses the halfword. Selector 01 matches only when bit 1 is 0 (lower), 10 only when bit 1 is 1 (upper), 11 for either, and 00 never matches.
- R6: A comparator produces an event only when the unit enable, its own enable and a non-zero selector are all set.
- R7: The event output is registered. It is high in the cycle after a matching fetch, for exactly one cycle per matching fetch, and it is the OR of all comparators.
- R8: No event is produced when the fetch-valid input is low.
- R9: Only fetch-address bits 28:2 are compared with the stored address. Bits 31:29 and bit 0 have no effect.
- R10: Comparator slots at or above the built count read 0, and writes to them never cause an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_addr_i | input | 32 | Instruction fetch address (halfword aligned) |
| bkpt_o | output | 1 | Registered breakpoint event |

## Verification
The bench probes both halfwords of each programmed word. A design that ignored address bit 1 would raise events on the wrong halfword for selectors 01 and 10. It writes the control word without the key bit and then checks that the enable did not change; a design that skipped the key check would switch the unit on or off. It builds three comparators and then programs the fourth, absent slot. A design that decoded beyond the built count would read back data there or fire on that address. Further cases cover selector 00 with the comparator enable set, fetches with valid low, differing upper address bits, and back-to-back matching fetches. These catch an event gated by the wrong enables, or a pulse that is stretched or merged across fetches.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned MAX_CMP      = 4;
  localparam int unsigned CTRL_WIDX    = 0;
  localparam int unsigned CMP_BASE_WIDX = 2;
  localparam int unsigned CMP_AW       = 27;  // word address bits 28:2

  typedef enum logic [1:0] {
    MS_NONE = 2'b00,
    MS_LO   = 2'b01,
    MS_HI   = 2'b10,
    MS_BOTH = 2'b11
  } match_sel_e;
endpackage

// File: rtl/bp_ctrl_reg.sv
module bp_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_o <= 1'b0;
    else if (wr_i && wdata_i[1]) en_o <= wdata_i[0];
  end

  AST_CTRL_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[1]) |=> $stable(en_o)); // R3
endmodule

// File: rtl/bp_comparator.sv
module bp_comparator
  import bp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        wsel_i,
  input  logic [CMP_AW-1:0] waddr_i,
  input  logic              wen_i,
  input  logic              unit_en_i,
  input  logic              fetch_valid_i,
  input  logic [CMP_AW-1:0] fetch_word_i,
  input  logic              fetch_hi_i,
  output logic              hit_o,
  output logic [31:0]       rdata_o
);
  match_sel_e        sel_q;
  logic [CMP_AW-1:0] addr_q;
  logic              en_q;
  logic              half_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= MS_NONE;
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_i) begin
      sel_q  <= match_sel_e'(wsel_i);
      addr_q <= waddr_i;
      en_q   <= wen_i;
    end
  end

  always_comb begin
    unique case (sel_q)
      MS_LO:   half_ok = !fetch_hi_i;
      MS_HI:   half_ok = fetch_hi_i;
      MS_BOTH: half_ok = 1'b1;
      default: half_ok = 1'b0;
    endcase
  end

  assign hit_o   = unit_en_i && en_q && fetch_valid_i && half_ok && (fetch_word_i == addr_q);
  assign rdata_o = {sel_q, 1'b0, addr_q, 1'b0, en_q};

  AST_CMP_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[28:2] == $past(waddr_i))); // R4
  AST_CMP_HIT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (rdata_o[0] && rdata_o[31:30] != 2'b00)); // R6
endmodule

// File: rtl/bp_event.sv
module bp_event #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hits_i,
  output logic         bkpt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bkpt_o <= 1'b0;
    else         bkpt_o <= |hits_i;
  end

  AST_EVT_ONE_PER_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hits_i == '0) |=> !bkpt_o); // R7
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bp_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  parameter int unsigned REG_AW  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              fetch_valid_i,
  input  logic [31:0]       fetch_addr_i,
  output logic              bkpt_o
);
  localparam int unsigned IDX_W = REG_AW - 2;
  localparam logic [3:0]  NUM_FIELD = 4'(NUM_CMP);

  logic [IDX_W-1:0] widx;
  logic             unit_en;
  logic             ctrl_wr;
  logic [MAX_CMP-1:0] hits;
  logic [31:0]      cmp_rdata [MAX_CMP];
  logic             unused_bits;

  assign widx        = reg_addr_i[REG_AW-1:2];
  assign ctrl_wr     = reg_wr_i && (widx == IDX_W'(CTRL_WIDX));
  assign unused_bits = ^{fetch_addr_i[31:29], fetch_addr_i[0], reg_wdata_i[29], reg_wdata_i[1],
                         reg_wdata_i[27:2] == '0, reg_addr_i[1:0]};

  bp_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (reg_wdata_i[1:0]),
    .en_o    (unit_en)
  );

  for (genvar k = 0; k < MAX_CMP; k++) begin : g_cmp
    if (k < NUM_CMP) begin : g_on
      logic sel_wr;
      assign sel_wr = reg_wr_i && (widx == IDX_W'(CMP_BASE_WIDX + k));
      bp_comparator u_cmp (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_i          (sel_wr),
        .wsel_i        (reg_wdata_i[31:30]),
        .waddr_i       (reg_wdata_i[28:2]),
        .wen_i         (reg_wdata_i[0]),
        .unit_en_i     (unit_en),
        .fetch_valid_i (fetch_valid_i),
        .fetch_word_i  (fetch_addr_i[28:2]),
        .fetch_hi_i    (fetch_addr_i[1]),
        .hit_o         (hits[k]),
        .rdata_o       (cmp_rdata[k])
      );
    end else begin : g_off
      assign hits[k]      = 1'b0;
      assign cmp_rdata[k] = '0;
    end
  end

  bp_event #(.N(MAX_CMP)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hits_i (hits),
    .bkpt_o (bkpt_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (widx == IDX_W'(CTRL_WIDX)) begin
      reg_rdata_o = {24'h0, NUM_FIELD, 3'b000, unit_en};
    end else begin
      for (int k = 0; k < MAX_CMP; k++) begin
        if (widx == IDX_W'(CMP_BASE_WIDX + k)) reg_rdata_o = cmp_rdata[k];
      end
    end
  end

  AST_EVT_NEEDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_o |-> $past(fetch_valid_i)); // R8
  AST_EVT_NEEDS_UNIT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_o |-> $past(unit_en)); // R6
endmodule

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCMP = 3;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 0;
  logic [31:0] fetch_addr = 0;
  logic        bkpt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; bit exp; string req; } item_t;
  item_t q[$];

  bkpt_unit #(.NUM_CMP(NCMP), .REG_AW(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fetch_valid_i(fetch_valid),
    .fetch_addr_i(fetch_addr), .bkpt_o(bkpt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (bkpt !== it.exp) begin
        n_fail++;
        $display("FAIL %s event got=%0b exp=%0b", it.req, bkpt, it.exp);
      end
    end
  end

  task automatic drive(bit wr, logic [5:0] a, logic [31:0] d, bit v, logic [31:0] fa,
                       bit exp, string req);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    fetch_valid = v; fetch_addr = fa;
    q.push_back('{due: cyc + 1, exp: exp, req: req});
  endtask

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    drive(1, a, d, 0, 0, 0, "R8");
  endtask

  task automatic fetch(logic [31:0] fa, bit exp, string req);
    drive(0, 0, 0, 1, fa, exp, req);
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_wr = 0; fetch_valid = 0; reg_addr = a;
    q.push_back('{due: cyc + 1, exp: 0, req: req});
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read @%0h got=%08h exp=%08h", req, a, reg_rdata, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (bkpt !== 1'b0) begin n_fail++; $display("FAIL R1 bkpt got=%0b exp=0", bkpt); end
    rd_chk(6'h00, 32'h30, "R1");
    rd_chk(6'h08, 32'h0, "R1");
    rd_chk(6'h10, 32'h0, "R1");
    rst_ni = 1;
    @(negedge clk);

    // R3 keyless write ignored
    wr_reg(6'h00, 32'h1);
    rd_chk(6'h00, 32'h30, "R3");
    // R2 keyed write, count read-only, key bit reads 0
    wr_reg(6'h00, 32'hF3);
    rd_chk(6'h00, 32'h31, "R2");

    // R4 layout: comp0 lower halfword of 0x100, bits 29 and 1 forced set in write
    wr_reg(6'h08, 32'h6000_0103);
    rd_chk(6'h08, 32'h4000_0101, "R4");
    wr_reg(6'h0C, 32'h8000_0201);
    wr_reg(6'h10, 32'hDFFF_FFFD);
    rd_chk(6'h10, 32'hDFFF_FFFD, "R4");
    rd_chk(6'h04, 32'h0, "R4");
    rd_chk(6'h18, 32'h0, "R4");

    // R5 halfword selection
    fetch(32'h0000_0100, 1, "R5 lo");
    fetch(32'h0000_0102, 0, "R5 lo-miss");
    fetch(32'h0000_0202, 1, "R5 hi");
    fetch(32'h0000_0200, 0, "R5 hi-miss");
    fetch(32'h1FFF_FFFC, 1, "R5 both-lo");
    fetch(32'h1FFF_FFFE, 1, "R5 both-hi");
    fetch(32'h0000_0104, 0, "R5 other word");

    // R7 back-to-back then gap; OR across comparators
    fetch(32'h0000_0100, 1, "R7 b2b0");
    fetch(32'h0000_0202, 1, "R7 b2b1");
    drive(0, 0, 0, 0, 0, 0, "R7 gap");

    // R8 valid low
    drive(0, 0, 0, 0, 32'h0000_0100, 0, "R8");

    // R9 upper bits and bit0 ignored
    fetch(32'hE000_0100, 1, "R9 upper");
    fetch(32'h0000_0101, 1, "R9 bit0");

    // R10 absent comparator 3
    wr_reg(6'h14, 32'hC000_0301);
    rd_chk(6'h14, 32'h0, "R10");
    fetch(32'h0000_0300, 0, "R10");

    // R6 selector 00 with enable set
    wr_reg(6'h08, 32'h0000_0101);
    fetch(32'h0000_0100, 0, "R6 sel00");
    // R6 comparator enable clear
    wr_reg(6'h08, 32'h4000_0100);
    fetch(32'h0000_0100, 0, "R6 cmp off");
    // R6 unit disabled
    wr_reg(6'h08, 32'h4000_0101);
    fetch(32'h0000_0100, 1, "R6 re-on");
    wr_reg(6'h00, 32'h2);
    rd_chk(6'h00, 32'h30, "R2");
    fetch(32'h0000_0100, 0, "R6 unit off");
    // R3 keyless write cannot re-enable
    wr_reg(6'h00, 32'h1);
    fetch(32'h0000_0100, 0, "R3");

    drive(0, 0, 0, 0, 0, 0, "R7 tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule